// File: doc/BRIEF.md
# Overcurrent Hiccup Retry Controller

This block decides, every clock, whether each of several high-side output switches may conduct. Each channel follows its synchronous control input until its current limiter raises an overcurrent flag. It then keeps conducting in current-limited mode for a programmable on window. If the overcurrent is still present when that window ends, the switch is forced off for a separate programmable off window. When the off window ends, the channel either retries with a new on window or, if the overcurrent has cleared, goes back to following its input. The retry cycle repeats for as long as the short lasts, so the heat from a sustained short is spread over time and no single channel has to shut down the whole device.

Both window lengths are shared by all channels and given as tick counts. An off setting of zero selects an off window 64 times as long as the on window. A setting of zero for both turns the protection off. A supervisor enable switches every output off at once and returns every channel to normal operation.

Top module: `hiccup_ctrl`

## Requirements
- R1: With no overcurrent, `drv_en[i]` equals `ctl_in[i] & sup_en` in the same cycle, and `lim_act[i]` and `flt[i]` stay low.
- R2: An overcurrent seen at a clock edge while the channel follows its input starts an on window from the next cycle. The window lasts `max(on_ticks,1)` cycles, with `drv_en` and `lim_act` high and `flt` low.
- R3: If the overcurrent flag is high in the last cycle of an on window, an off window of `off_ticks` cycles follows, with `drv_en` low, `flt` high and `lim_act` low.
- R4: If the overcurrent flag is high in the last cycle of an off window, a new on window follows. Otherwise the channel returns to following its input.
- R5: If the overcurrent flag is low in the last cycle of an on window, the channel returns to following its input in the next cycle.
- R6: When `off_ticks` is zero and `on_ticks` is not, the off window lasts 64 times `on_ticks` cycles.
- R7: When `on_ticks` and `off_ticks` are both zero, an overcurrent has no effect: `drv_en` follows the input, and `lim_act` and `flt` stay low.
- R8: `flt[i]` is high only during an off window. It is never high together with `lim_act[i]` or `drv_en[i]`.
- R9: Channels are independent: a short on one channel changes no output of another.
- R10: The window length is taken from the settings in the cycle the window starts. A change made during a window affects only later windows.
- R11: A low `ctl_in[i]` forces all three outputs of channel i low in the same cycle, and at the next edge the channel returns to following its input with its timer cleared.
- R12: A low `sup_en` forces every output low in the same cycle, and at the next edge every channel returns to following its input.
- R13: After the asynchronous active-low reset, every channel follows its input, and with all inputs low all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sup_en | input | 1 | Supervisor enable; low forces all outputs off |
| on_ticks | input | TW | On-window length in ticks |
| off_ticks | input | TW | Off-window length in ticks (0 selects 64 x on) |
| ctl_in | input | NCH | Per-channel control input |
| oc_flag | input | NCH | Per-channel overcurrent flag from the current limiter |
| drv_en | output | NCH | Per-channel output-switch enable |
| lim_act | output | NCH | Per-channel current-limited conduction indication |
| flt | output | NCH | Per-channel fault, high during the off window |

## Verification
The bench builds the block with four channels and an 8-bit tick width. It keeps the windows to two to four ticks, so that each step of the retry cycle falls on a short table of per-cycle vectors. With the 8-bit width, the 64-times off window for an on setting of 3 is only 192 cycles long, so its exact length can be counted. Changing a setting partway through a window, and shorting one channel while the other three are driven, check sampling at window start and channel independence.

// File: rtl/hiccup_ctrl.sv
module hiccup_ctrl #(
  parameter int NCH = 4,
  parameter int TW = 16,
  parameter int OFF_SHIFT = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sup_en,
  input  logic [TW-1:0]  on_ticks,
  input  logic [TW-1:0]  off_ticks,
  input  logic [NCH-1:0] ctl_in,
  input  logic [NCH-1:0] oc_flag,
  output logic [NCH-1:0] drv_en,
  output logic [NCH-1:0] lim_act,
  output logic [NCH-1:0] flt
);
  localparam int CW = TW + OFF_SHIFT;
  localparam logic [1:0] S_RUN = 2'd0, S_LIM = 2'd1, S_HOLD = 2'd2;

  logic          prot_off;
  logic [CW-1:0] on_len, off_len;

  assign prot_off = (on_ticks == '0) && (off_ticks == '0);
  assign on_len   = (on_ticks == '0) ? CW'(1) : CW'(on_ticks);
  assign off_len  = (off_ticks == '0) ? (CW'(on_ticks) << OFF_SHIFT) : CW'(off_ticks);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [1:0]    st;
    logic [CW-1:0] cnt;
    logic          live, last;

    assign live = sup_en & ctl_in[g];
    assign last = (cnt <= CW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st  <= S_RUN;
        cnt <= '0;
      end else if (!live) begin
        st  <= S_RUN;
        cnt <= '0;
      end else begin
        case (st)
          S_RUN: if (oc_flag[g] && !prot_off) begin
            st  <= S_LIM;
            cnt <= on_len;
          end
          S_LIM: if (!last) cnt <= cnt - CW'(1);
          else if (oc_flag[g]) begin
            st  <= S_HOLD;
            cnt <= off_len;
          end else begin
            st  <= S_RUN;
            cnt <= '0;
          end
          S_HOLD: if (!last) cnt <= cnt - CW'(1);
          else if (oc_flag[g]) begin
            st  <= S_LIM;
            cnt <= on_len;
          end else begin
            st  <= S_RUN;
            cnt <= '0;
          end
          default: begin
            st  <= S_RUN;
            cnt <= '0;
          end
        endcase
      end
    end

    assign drv_en[g]  = live & (st != S_HOLD);
    assign lim_act[g] = live & (st == S_LIM);
    assign flt[g]     = live & (st == S_HOLD);
  end
endmodule

// File: rtl/hiccup_ctrl_chk.sv
module hiccup_ctrl_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           sup_en,
  input logic [NCH-1:0] ctl_in,
  input logic [NCH-1:0] drv_en,
  input logic [NCH-1:0] lim_act,
  input logic [NCH-1:0] flt
);
  p_force_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !sup_en |-> (drv_en == '0) && (lim_act == '0) && (flt == '0));

  for (genvar i = 0; i < NCH; i++) begin : g_a
    p_fault_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      flt[i] |-> !lim_act[i] && !drv_en[i]);

    p_ctl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_in[i] |-> !drv_en[i] && !lim_act[i] && !flt[i]);

    p_fault_after_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flt[i]) |-> $past(lim_act[i]));

    p_lim_conducts_r2: assert property (@(posedge clk) disable iff (!rst_n)
      lim_act[i] |-> drv_en[i]);
  end
endmodule

bind hiccup_ctrl hiccup_ctrl_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .sup_en(sup_en), .ctl_in(ctl_in),
  .drv_en(drv_en), .lim_act(lim_act), .flt(flt)
);

// File: tb/test_hiccup_ctrl.sv
`timescale 1ns/1ps
module test_hiccup_ctrl;
  localparam int NCH = 4;
  localparam int TW = 8;
  localparam int NV = 25;
  // {ctl, oc, sup, exp_drv, exp_lim, exp_flt} for channel 0, on=2 off=3
  localparam logic [5:0] VEC [NV] = '{
    6'b101_100, 6'b111_100, 6'b111_110, 6'b111_110, 6'b111_001,
    6'b111_001, 6'b111_001, 6'b101_110, 6'b101_110, 6'b111_100,
    6'b111_110, 6'b111_110, 6'b101_001, 6'b101_001, 6'b101_001,
    6'b101_100, 6'b001_000, 6'b111_100, 6'b111_110, 6'b111_110,
    6'b011_000, 6'b101_100, 6'b111_100, 6'b110_000, 6'b101_100
  };

  logic clk = 0, rst_n = 0, sup_en = 1;
  logic [TW-1:0] on_ticks = 8'd2, off_ticks = 8'd3;
  logic [NCH-1:0] ctl_in = '0, oc_flag = '0;
  logic [NCH-1:0] drv_en, lim_act, flt;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hiccup_ctrl #(.NCH(NCH), .TW(TW)) i_hiccup_ctrl (
    .clk(clk), .rst_n(rst_n), .sup_en(sup_en), .on_ticks(on_ticks),
    .off_ticks(off_ticks), .ctl_in(ctl_in), .oc_flag(oc_flag),
    .drv_en(drv_en), .lim_act(lim_act), .flt(flt)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic string row_tag(input int i);
    if (i == 0) return "R1";
    if (i <= 3 || (i >= 9 && i <= 11) || (i >= 17 && i <= 19)) return "R2";
    if ((i >= 4 && i <= 5) || (i >= 12 && i <= 14)) return "R3";
    if (i == 6 || i == 7 || i == 15) return "R4";
    if (i == 8) return "R5";
    if (i == 16 || i == 20 || i == 21) return "R11";
    return "R12";
  endfunction

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  // counts consecutive samples in which the selected signal of channel ch is high
  task automatic run_len(input int kind, input int ch, output int n);
    n = 0;
    while ((kind == 0) ? lim_act[ch] : flt[ch]) begin
      n++;
      step();
    end
  endtask

  task automatic wait_high(input int kind, input int ch);
    for (int k = 0; k < 50; k++) begin
      if ((kind == 0) ? lim_act[ch] : flt[ch]) break;
      step();
    end
  endtask

  task automatic to_idle();
    @(negedge clk);
    ctl_in = '0; oc_flag = '0; sup_en = 1;
    step();
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int n;
    int bad;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R13 reset outputs", {drv_en, lim_act, flt}, 0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      ctl_in[0] = VEC[i][5]; oc_flag[0] = VEC[i][4]; sup_en = VEC[i][3];
      #1;
      chk($sformatf("%s row %0d", row_tag(i), i),
          {drv_en[0], lim_act[0], flt[0]}, VEC[i][2:0]);
    end

    // R6: off setting zero gives 64x the on window
    to_idle();
    on_ticks = 8'd3; off_ticks = 8'd0;
    ctl_in[0] = 1; oc_flag[0] = 1;
    wait_high(0, 0);
    run_len(0, 0, n);
    chk("R2 on window length 3", n, 3);
    run_len(1, 0, n);
    chk("R6 off window 64x on", n, 192);

    // R10: setting change inside a window
    to_idle();
    on_ticks = 8'd2; off_ticks = 8'd4;
    ctl_in[0] = 1; oc_flag[0] = 1;
    wait_high(1, 0);
    off_ticks = 8'd10;
    run_len(1, 0, n);
    chk("R10 current off window keeps old length", n, 4);
    run_len(0, 0, n);
    chk("R10 next on window", n, 2);
    run_len(1, 0, n);
    chk("R10 next off window uses new length", n, 10);

    // R7: protection disabled
    to_idle();
    on_ticks = 8'd0; off_ticks = 8'd0;
    ctl_in[0] = 1; oc_flag[0] = 1;
    bad = 0;
    for (int k = 0; k < 40; k++) begin
      step();
      if ({drv_en[0], lim_act[0], flt[0]} != 3'b100) bad++;
    end
    chk("R7 disabled protection keeps channel on", bad, 0);

    // R2: on setting zero still gives a one-cycle window
    to_idle();
    on_ticks = 8'd0; off_ticks = 8'd3;
    ctl_in[0] = 1; oc_flag[0] = 1;
    wait_high(0, 0);
    run_len(0, 0, n);
    chk("R2 zero on setting gives 1 cycle", n, 1);
    run_len(1, 0, n);
    chk("R3 off window length 3", n, 3);

    // R9: one shorted channel, others unaffected
    to_idle();
    on_ticks = 8'd2; off_ticks = 8'd3;
    ctl_in = '1; oc_flag[1] = 1;
    bad = 0; n = 0;
    for (int k = 0; k < 30; k++) begin
      step();
      if (flt[1]) n++;
      if ({drv_en[0], drv_en[2], drv_en[3]} != 3'b111) bad++;
      if ((lim_act | flt) & 4'b1101) bad++;
    end
    chk("R9 other channels unaffected", bad, 0);
    chk("R9 shorted channel reports fault", n > 0, 1);

    // R12 with several channels in protection
    @(negedge clk);
    sup_en = 0;
    #1;
    chk("R12 all outputs off", {drv_en, lim_act, flt}, 0);
    @(negedge clk);
    sup_en = 1; oc_flag = '0;
    #1;
    chk("R12 all channels back to input following", {drv_en, lim_act, flt}, 12'hF00);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule